// File: doc/BRIEF.md
# Peripheral idle and reset controller

This block is the configuration and power-management front end of a serial peripheral. It holds a single 32-bit register on a simple register bus: a two-bit clock-activity field, a two-bit idle policy field and an auto-idle bit. A write-only soft-reset bit also sits in that register. The system raises an idle request, and the block answers with an acknowledge that follows the selected policy. The policy can be forced (acknowledge at once), ignored (never acknowledge) or smart (acknowledge only once the core has gone quiet). While idle is acknowledged, the peripheral's interrupt and DMA request lines are held low.

Writing the soft-reset bit starts a fixed-length reset pulse for the rest of the peripheral. The configuration register itself is not affected by that pulse. A done flag rises once the pulse ends. An interface clock enable is derived from bus activity when auto-idle is set, and is held on when it is clear. The clock-activity field is brought out as two "keep clock running" flags for the clock controller.

Top module: `pwrIdleCtl`

## Requirements
- R1: After hardware reset the register reads 0x00000011: clock activity 0 in bits 9:8, idle mode 2 in bits 4:3, auto-idle 1 in bit 0. The acknowledge, the module-reset output and the done flag are all low.
- R2: A write updates bits 9:8, 4:3 and 0. Every other bit reads as 0, including the soft-reset bit (bit 1), and writes to those other bits are ignored.
- R3: With idle mode 0 (forced), the acknowledge follows the idle request in the same cycle. It rises when the request rises and falls when the request falls.
- R4: With idle mode 1 (ignore) or 3 (reserved), the acknowledge stays low however long the idle request stays high.
- R5: With idle mode 2 (smart), the acknowledge is high only while the request is high and the busy input is low in both the current and the previous cycle. It drops in the same cycle the request is withdrawn.
- R6: While the acknowledge is high, the interrupt and DMA request outputs are 0. Otherwise they equal their inputs.
- R7: A write with bit 1 set drives the module-reset output high for exactly 4 cycles, starting at the first clock edge after the write. The done flag is low during the pulse and goes high in the cycle the pulse ends.
- R8: The soft reset leaves the register fields unchanged.
- R9: With auto-idle 0 the interface clock enable is always 1. With auto-idle 1 it is 1 only in a cycle with a bus access and in the cycle after it.
- R10: The keep-interface-clock output equals bit 8 of the register, and the keep-functional-clock output equals bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset |
| busSel | input | 1 | Register access in this cycle |
| busWr | input | 1 | Access is a write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Register read value |
| idleReq | input | 1 | Idle request from the system |
| coreBusy | input | 1 | Peripheral core has internal activity |
| idleAck | output | 1 | Idle acknowledge |
| irqIn | input | 1 | Interrupt from the core |
| dmaIn | input | 1 | DMA request from the core |
| irqOut | output | 1 | Interrupt after idle masking |
| dmaOut | output | 1 | DMA request after idle masking |
| modRstOut | output | 1 | Reset pulse for the peripheral core |
| rstDone | output | 1 | Soft reset pulse has completed |
| ifClkEn | output | 1 | Interface clock enable |
| keepIfClk | output | 1 | Keep interface clock during wake-up |
| keepFnClk | output | 1 | Keep functional clock during wake-up |

## Verification
In smart mode the bench drops the busy input and checks that the acknowledge stays low for that first quiet cycle. A design that skips this one-cycle history check would acknowledge too early. The bench also withdraws the request and checks that the acknowledge falls in the same cycle. A registered acknowledge would lag by one cycle here and fail. The soft-reset pulse is counted edge by edge and the register is read back afterwards, which catches an off-by-one pulse length and a soft reset that wipes the fields. The bench holds the idle request high in the ignore and reserved modes, and samples the clock enable two cycles after an access; these expose a decoder that treats mode 3 as forced and a gate that releases too early or too late.

// File: rtl/pwrIdlePkg.sv
package pwrIdlePkg;
  localparam int CLKACT_LSB = 8;
  localparam int IDLE_LSB   = 3;
  localparam int SRST_BIT   = 1;
  localparam int AUTO_BIT   = 0;

  typedef enum logic [1:0] {
    IDLE_FORCE = 2'd0,
    IDLE_NONE  = 2'd1,
    IDLE_SMART = 2'd2,
    IDLE_RSVD  = 2'd3
  } idleMode_e;

  typedef struct packed {
    logic [1:0] clkAct;
    idleMode_e  idleMode;
    logic       autoIdle;
  } cfg_t;

  typedef struct packed {
    logic access;
    logic cfgWrite;
    logic rstStart;
  } ctlStrobe_t;
endpackage

// File: rtl/pwrIdleDatapath.sv
module pwrIdleDatapath
  import pwrIdlePkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              idleAck,
  input  logic              irqIn,
  input  logic              dmaIn,
  output cfg_t              cfgQ,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic              dmaOut,
  output logic              keepIfClk,
  output logic              keepFnClk
);
  logic unusedWdata;
  assign unusedWdata = ^busWdata;

  // configuration register: only hardware reset clears it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ.clkAct   <= 2'd0;
      cfgQ.idleMode <= IDLE_SMART;
      cfgQ.autoIdle <= 1'b1;
    end else if (strobe.cfgWrite) begin
      cfgQ.clkAct   <= busWdata[CLKACT_LSB +: 2];
      cfgQ.idleMode <= idleMode_e'(busWdata[IDLE_LSB +: 2]);
      cfgQ.autoIdle <= busWdata[AUTO_BIT];
    end
  end

  always_comb begin
    busRdata = '0;
    busRdata[CLKACT_LSB +: 2] = cfgQ.clkAct;
    busRdata[IDLE_LSB +: 2]   = cfgQ.idleMode;
    busRdata[AUTO_BIT]        = cfgQ.autoIdle;
  end

  assign irqOut    = irqIn & ~idleAck;
  assign dmaOut    = dmaIn & ~idleAck;
  assign keepIfClk = cfgQ.clkAct[0];
  assign keepFnClk = cfgQ.clkAct[1];

  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.cfgWrite |=> $stable(cfgQ));
  p_cfg_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cfgWrite |=> cfgQ.idleMode == $past(busWdata[IDLE_LSB +: 2]));
  p_mask_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    idleAck |-> (!irqOut && !dmaOut));
endmodule

// File: rtl/pwrIdleControl.sv
module pwrIdleControl
  import pwrIdlePkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busSel,
  input  logic       busWr,
  input  logic       srstBit,
  input  cfg_t       cfgQ,
  input  logic       idleReq,
  input  logic       coreBusy,
  output ctlStrobe_t strobe,
  output logic       idleAck,
  output logic       modRstOut,
  output logic       rstDone,
  output logic       ifClkEn
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0] rstCnt;
  logic             quietQ;
  logic             accessQ;

  assign strobe.access   = busSel;
  assign strobe.cfgWrite = busSel & busWr;
  assign strobe.rstStart = busSel & busWr & srstBit;

  // soft reset pulse counter and done flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstCnt  <= '0;
      rstDone <= 1'b0;
    end else if (strobe.rstStart) begin
      rstCnt  <= CNT_W'(RST_CYCLES);
      rstDone <= 1'b0;
    end else if (rstCnt != '0) begin
      rstCnt  <= rstCnt - 1'b1;
      if (rstCnt == CNT_W'(1)) rstDone <= 1'b1;
    end
  end
  assign modRstOut = (rstCnt != '0);

  // history of core activity and bus activity
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quietQ  <= 1'b0;
      accessQ <= 1'b0;
    end else begin
      quietQ  <= ~coreBusy;
      accessQ <= strobe.access;
    end
  end

  always_comb begin
    unique case (cfgQ.idleMode)
      IDLE_FORCE: idleAck = idleReq;
      IDLE_SMART: idleAck = idleReq & ~coreBusy & quietQ;
      default:    idleAck = 1'b0;
    endcase
  end

  assign ifClkEn = ~cfgQ.autoIdle | strobe.access | accessQ;

  p_ack_needs_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    idleAck |-> idleReq);
  p_no_ack_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ.idleMode == IDLE_NONE || cfgQ.idleMode == IDLE_RSVD) |-> !idleAck);
  p_smart_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ.idleMode == IDLE_SMART && idleAck) |-> !coreBusy);
  p_rst_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rstStart |=> modRstOut);
  p_rst_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(modRstOut) |-> rstDone);
  p_clk_after_access_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.access |=> ifClkEn);
endmodule

// File: rtl/pwrIdleCtl.sv
module pwrIdleCtl
  import pwrIdlePkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              idleReq,
  input  logic              coreBusy,
  output logic              idleAck,
  input  logic              irqIn,
  input  logic              dmaIn,
  output logic              irqOut,
  output logic              dmaOut,
  output logic              modRstOut,
  output logic              rstDone,
  output logic              ifClkEn,
  output logic              keepIfClk,
  output logic              keepFnClk
);
  ctlStrobe_t strobe;
  cfg_t       cfgQ;

  pwrIdleControl #(.RST_CYCLES(RST_CYCLES)) i_control (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .srstBit(busWdata[SRST_BIT]), .cfgQ(cfgQ), .idleReq(idleReq),
    .coreBusy(coreBusy), .strobe(strobe), .idleAck(idleAck),
    .modRstOut(modRstOut), .rstDone(rstDone), .ifClkEn(ifClkEn)
  );

  pwrIdleDatapath #(.DATA_W(DATA_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .idleAck(idleAck), .irqIn(irqIn), .dmaIn(dmaIn), .cfgQ(cfgQ),
    .busRdata(busRdata), .irqOut(irqOut), .dmaOut(dmaOut),
    .keepIfClk(keepIfClk), .keepFnClk(keepFnClk)
  );
endmodule

// File: tb/test_pwrIdleCtl.sv
module test_pwrIdleCtl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [31:0] busWdata = '0, busRdata;
  logic        idleReq = 1'b0, coreBusy = 1'b0, idleAck;
  logic        irqIn = 1'b0, dmaIn = 1'b0, irqOut, dmaOut;
  logic        modRstOut, rstDone, ifClkEn, keepIfClk, keepFnClk;
  int          nChecks = 0, nFails = 0, cycles = 0;

  always #10 clk = ~clk;

  pwrIdleCtl i_pwrIdleCtl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .idleReq(idleReq),
    .coreBusy(coreBusy), .idleAck(idleAck), .irqIn(irqIn), .dmaIn(dmaIn),
    .irqOut(irqOut), .dmaOut(dmaOut), .modRstOut(modRstOut),
    .rstDone(rstDone), .ifClkEn(ifClkEn), .keepIfClk(keepIfClk),
    .keepFnClk(keepFnClk)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [31:0] d);
    @(negedge clk); busSel = 1'b1; busWr = 1'b1; busWdata = d;
    @(negedge clk); busSel = 1'b0; busWr = 1'b0; busWdata = '0;
  endtask

  task automatic readCheck(input string req, input logic [31:0] exp);
    @(negedge clk); busSel = 1'b1; busWr = 1'b0; #1;
    check(req, busRdata, exp);
    @(negedge clk); busSel = 1'b0;
  endtask

  task automatic testReset();
    #1;
    check("R1 rdata", busRdata, 32'h11);
    check("R1 ack", 32'(idleAck), 0);
    check("R1 modRst", 32'(modRstOut), 0);
    check("R1 done", 32'(rstDone), 0);
  endtask

  task automatic testFields();
    writeReg(32'hFFFF_FFFF);
    readCheck("R2 reserved/srst read 0", 32'h319);
    repeat (6) @(negedge clk);
    writeReg(32'h0000_0011);
    readCheck("R2 restore", 32'h11);
  endtask

  task automatic testForced();
    writeReg(32'h01);
    @(negedge clk); idleReq = 1'b1; #1; check("R3 ack rise", 32'(idleAck), 1);
    @(negedge clk); #1; check("R3 ack held", 32'(idleAck), 1);
    idleReq = 1'b0; #1; check("R3 ack fall", 32'(idleAck), 0);
  endtask

  task automatic testNoIdle();
    writeReg(32'h09);
    idleReq = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1; check("R4 mode1 no ack", 32'(idleAck), 0);
    end
    idleReq = 1'b0;
    writeReg(32'h19);
    idleReq = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1; check("R4 mode3 no ack", 32'(idleAck), 0);
    end
    idleReq = 1'b0;
  endtask

  task automatic testSmart();
    writeReg(32'h11);
    coreBusy = 1'b1; idleReq = 1'b1;
    @(negedge clk); #1; check("R5 busy no ack", 32'(idleAck), 0);
    @(negedge clk); coreBusy = 1'b0; #1; check("R5 first quiet no ack", 32'(idleAck), 0);
    @(negedge clk); #1; check("R5 ack after quiet", 32'(idleAck), 1);
    idleReq = 1'b0; #1; check("R5 ack drops with req", 32'(idleAck), 0);
    @(negedge clk); idleReq = 1'b1; coreBusy = 1'b1; #1;
    check("R5 busy again no ack", 32'(idleAck), 0);
    @(negedge clk); idleReq = 1'b0; coreBusy = 1'b0;
  endtask

  task automatic testMask();
    writeReg(32'h01);
    @(negedge clk); irqIn = 1'b1; dmaIn = 1'b1; #1;
    check("R6 irq pass", 32'(irqOut), 1);
    check("R6 dma pass", 32'(dmaOut), 1);
    idleReq = 1'b1; #1;
    check("R6 irq masked", 32'(irqOut), 0);
    check("R6 dma masked", 32'(dmaOut), 0);
    @(negedge clk); idleReq = 1'b0; irqIn = 1'b0; dmaIn = 1'b0;
  endtask

  task automatic testSoftReset();
    writeReg(32'h30B);
    for (int i = 0; i < 4; i++) begin
      #1; check("R7 pulse high", 32'(modRstOut), 1);
      check("R7 done low", 32'(rstDone), 0);
      @(negedge clk);
    end
    #1; check("R7 pulse end", 32'(modRstOut), 0);
    check("R7 done high", 32'(rstDone), 1);
    readCheck("R8 fields kept", 32'h309);
  endtask

  task automatic testAutoIdle();
    writeReg(32'h10);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1; check("R9 free running", 32'(ifClkEn), 1);
    end
    writeReg(32'h11);
    #1; check("R9 cycle after access", 32'(ifClkEn), 1);
    @(negedge clk); #1; check("R9 gated off", 32'(ifClkEn), 0);
    @(negedge clk); busSel = 1'b1; #1; check("R9 access cycle", 32'(ifClkEn), 1);
    @(negedge clk); busSel = 1'b0; #1; check("R9 access +1", 32'(ifClkEn), 1);
    @(negedge clk); #1; check("R9 access +2 gated", 32'(ifClkEn), 0);
  endtask

  task automatic testClkAct();
    writeReg(32'h111);
    #1; check("R10 keepIf", 32'(keepIfClk), 1); check("R10 keepFn", 32'(keepFnClk), 0);
    writeReg(32'h211);
    #1; check("R10 keepIf off", 32'(keepIfClk), 0); check("R10 keepFn on", 32'(keepFnClk), 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testFields();
    testForced();
    testNoIdle();
    testSmart();
    testMask();
    testSoftReset();
    testAutoIdle();
    testClkAct();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule